// File: doc/BRIEF.md
# Posit Word Decoder

This block turns one N-bit posit code into its parts: a sign, flags for the two special codes, a signed power-of-two scale and a fraction with its hidden bit written out. A posit stores its magnitude as a run of identical bits that starts just below the sign bit. The length of that run sets a coarse scale in steps of 2^(2^ES). Exponent bits and fraction bits follow the run and its ending bit, so where they sit in the word depends on how long the run is. The decoder measures the run, shifts the rest of the word into place and puts together the total scale. A word goes in with a valid strobe, and the decoded fields come out registered one cycle later.

Negative codes are first negated as whole two's-complement words. When the run fills the rest of the word, there is no ending bit, and every exponent and fraction bit that does not fit in the word reads as zero. There is no NaN and there are no subnormals. The all-zero word is zero. A one followed by all zeros is the single infinity.

The output register holds a class state with three values: `CLS_ZERO`, `CLS_INF` and `CLS_REAL`. Reset puts it in `CLS_ZERO`. On each cycle with the strobe high, it moves to the class of the word accepted in that cycle, from any state to any state. With the strobe low it stays where it is.

Top module: `posit_word_decoder`

## Requirements
- R1: The all-zero word decodes with zero_o=1, inf_o=0, sign_o=0, scale_o=0 and frac_o=0.
- R2: The word with only its top bit set decodes with inf_o=1, zero_o=0, sign_o=1, scale_o=0 and frac_o=0.
- R3: sign_o equals the top bit of the word. A word with its top bit set, other than infinity, decodes exactly like its two's-complement negation apart from sign_o (N=8: 0xC0 gives scale 0, as 0x40 does).
- R4: A run of m ones below the sign, ended by a zero, gives regime m-1. scale_o = regime*2^ES + exponent, read as a signed value (N=8, ES=1: 0x50 gives scale 1).
- R5: A run of m zeros below the sign, ended by a one, gives regime -m (N=8, ES=1: 0x20 gives scale -2).
- R6: A run that reaches bit 0 with no ending bit gives regime N-2 for ones and -(N-2) for zeros (N=8, ES=1: 0x7F gives scale 12, 0x01 gives scale -12).
- R7: Exponent bits that fall past bit 0 of the word read as zero (N=8, ES=1: 0x7E gives scale 10).
- R8: For a real code, frac_o has width N-2-ES. Its top bit is a hidden 1, followed by the fraction bits from the most significant down, with zeros filling any missing bits (N=8, ES=1: 0x47 gives frac_o=5'b10111).
- R9: The outputs show the word accepted on one rising edge after that edge. valid_o is high exactly in the cycle after a cycle in which valid_i was high.
- R10: With valid_i low, sign_o, zero_o, inf_o, scale_o and frac_o keep their values.
- R11: While reset is active, and after it is released, the block shows valid_o=0 and the zero class (zero_o=1, all other fields 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Strobe: word_i is accepted this cycle |
| word_i | input | N | Posit code |
| valid_o | output | 1 | Decoded fields belong to a word accepted in the last cycle |
| sign_o | output | 1 | Sign bit of the accepted word |
| zero_o | output | 1 | Accepted word is the zero code |
| inf_o | output | 1 | Accepted word is the infinity code |
| scale_o | output | SCALE_W | Signed scale, regime*2^ES + exponent |
| frac_o | output | N-2-ES | Hidden 1 followed by fraction bits |

## Verification
All 2^N codes go through the decoder, and each result is compared with a decoder in the bench that walks the bits one at a time. Most of the risk sits at the ends of the run. A counter that is off by one at a run of full length would give 0x7F and 0x01 a wrong regime, or would shift garbage into the fraction. A regime off by one on the zeros side would move every negative scale by 2^ES. Negating only part of the word would decode negative codes with the wrong magnitude. Idle cycles placed between the vectors expose fields that change while the strobe is low.

// File: rtl/posit_dec_pkg.sv
package posit_dec_pkg;

    typedef enum logic [1:0] {
        CLS_ZERO = 2'd0,
        CLS_INF  = 2'd1,
        CLS_REAL = 2'd2
    } posit_cls_e;

endpackage

// File: rtl/posit_classify.sv
module posit_classify
    import posit_dec_pkg::*;
#(
    parameter int N = 8
) (
    input  logic [N-1:0] word_i,
    output posit_cls_e   cls_o,
    output logic [N-2:0] body_o
);
    localparam logic [N-1:0] INF_CODE = {1'b1, {(N-1){1'b0}}};

    logic [N-1:0] mag;

    always_comb begin
        mag = word_i[N-1] ? (~word_i + {{(N-1){1'b0}}, 1'b1}) : word_i;
        body_o = mag[N-2:0];
        if (word_i == '0) begin
            cls_o = CLS_ZERO;
        end else if (word_i == INF_CODE) begin
            cls_o = CLS_INF;
        end else begin
            cls_o = CLS_REAL;
        end
    end

endmodule

// File: rtl/posit_lead_run.sv
module posit_lead_run #(
    parameter int W = 7,
    localparam int RUN_W = $clog2(W + 1)
) (
    input  logic [W-1:0]     bits_i,
    output logic             lead_o,
    output logic [RUN_W-1:0] run_o
);
    always_comb begin
        logic alive;
        lead_o = bits_i[W-1];
        run_o  = '0;
        alive  = 1'b1;
        for (int i = W - 1; i >= 0; i--) begin
            if (alive && (bits_i[i] == lead_o)) begin
                run_o = run_o + RUN_W'(1);
            end else begin
                alive = 1'b0;
            end
        end
    end

endmodule

// File: rtl/posit_field_extract.sv
module posit_field_extract #(
    parameter int N = 8,
    parameter int ES = 1,
    localparam int RUN_W   = $clog2(N),
    localparam int REST_W  = N - 3,
    localparam int FRAC_W  = N - 3 - ES,
    localparam int SCALE_W = $clog2(((N - 1) << ES) + 1) + 1
) (
    input  logic [REST_W-1:0]         rest_i,
    input  logic                      lead_i,
    input  logic [RUN_W-1:0]          run_i,
    output logic signed [SCALE_W-1:0] scale_o,
    output logic [FRAC_W:0]           frac_o
);
    logic [REST_W-1:0]         aligned;
    logic [RUN_W-1:0]          shamt;
    logic signed [SCALE_W-1:0] regime;
    logic signed [SCALE_W-1:0] run_s;
    logic signed [SCALE_W-1:0] exp_s;

    always_comb begin
        // The top two body bits always belong to the run or its end bit.
        if (run_i == RUN_W'(N - 1)) begin
            shamt = RUN_W'(N - 3);
        end else begin
            shamt = run_i - RUN_W'(1);
        end
        aligned = rest_i << shamt;

        run_s  = $signed({{(SCALE_W - RUN_W){1'b0}}, run_i});
        regime = lead_i ? (run_s - SCALE_W'(1)) : -run_s;
        exp_s  = $signed({{(SCALE_W - ES){1'b0}}, aligned[REST_W-1 -: ES]});

        scale_o = (regime <<< ES) + exp_s;
        frac_o  = {1'b1, aligned[FRAC_W-1:0]};
    end

endmodule

// File: rtl/posit_word_decoder.sv
module posit_word_decoder
    import posit_dec_pkg::*;
#(
    parameter int N = 8,
    parameter int ES = 1,
    localparam int FRAC_W  = N - 3 - ES,
    localparam int SCALE_W = $clog2(((N - 1) << ES) + 1) + 1
) (
    input  logic                      clk_i,
    input  logic                      rst_ni,
    input  logic                      valid_i,
    input  logic [N-1:0]              word_i,
    output logic                      valid_o,
    output logic                      sign_o,
    output logic                      zero_o,
    output logic                      inf_o,
    output logic signed [SCALE_W-1:0] scale_o,
    output logic [FRAC_W:0]           frac_o
);
    localparam int RUN_W = $clog2(N);
    localparam logic [N-1:0] INF_CODE = {1'b1, {(N-1){1'b0}}};

    initial begin
        if (FRAC_W < 1) $error("posit_word_decoder needs ES < N-3");
    end

    posit_cls_e                cls_d, cls_q;
    logic [N-2:0]              body;
    logic                      lead;
    logic [RUN_W-1:0]          run;
    logic signed [SCALE_W-1:0] scale_d, scale_q;
    logic [FRAC_W:0]           frac_d, frac_q;
    logic                      sign_q;

    posit_classify #(.N(N)) classify_i (
        .word_i (word_i),
        .cls_o  (cls_d),
        .body_o (body)
    );

    posit_lead_run #(.W(N - 1)) lead_run_i (
        .bits_i (body),
        .lead_o (lead),
        .run_o  (run)
    );

    posit_field_extract #(.N(N), .ES(ES)) extract_i (
        .rest_i  (body[N-4:0]),
        .lead_i  (lead),
        .run_i   (run),
        .scale_o (scale_d),
        .frac_o  (frac_d)
    );

    // State register: class of the last accepted word and its fields.
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cls_q   <= CLS_ZERO;
            sign_q  <= 1'b0;
            scale_q <= '0;
            frac_q  <= '0;
            valid_o <= 1'b0;
        end else begin
            valid_o <= valid_i;
            if (valid_i) begin
                cls_q   <= cls_d;
                sign_q  <= word_i[N-1];
                scale_q <= scale_d;
                frac_q  <= frac_d;
            end
        end
    end

    // Output decode by class.
    always_comb begin
        sign_o  = sign_q;
        zero_o  = 1'b0;
        inf_o   = 1'b0;
        scale_o = '0;
        frac_o  = '0;
        unique case (cls_q)
            CLS_ZERO: zero_o = 1'b1;
            CLS_INF:  inf_o  = 1'b1;
            CLS_REAL: begin
                scale_o = scale_q;
                frac_o  = frac_q;
            end
            default: ;
        endcase
    end

    assert_zero_code_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (valid_i && word_i == '0) |=> (zero_o && !inf_o && !sign_o && scale_o == '0));

    assert_inf_code_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (valid_i && word_i == INF_CODE) |=> (inf_o && !zero_o && sign_o && frac_o == '0));

    assert_sign_follows_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        valid_i |=> (sign_o == $past(word_i[N-1])));

    assert_hidden_bit_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (valid_i && word_i != '0 && word_i != INF_CODE) |=> frac_o[FRAC_W]);

    assert_valid_latency_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        valid_i |=> valid_o);

    assert_valid_drop_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !valid_i |=> !valid_o);

    assert_hold_fields_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !valid_i |=> ($stable(scale_o) && $stable(frac_o) && $stable(sign_o)
                      && $stable(zero_o) && $stable(inf_o)));

endmodule

// File: tb/posit_word_decoder_tb.sv
module posit_word_decoder_tb_top;
    localparam int N = 8;
    localparam int ES = 1;
    localparam int FRAC_W  = N - 3 - ES;
    localparam int SCALE_W = $clog2(((N - 1) << ES) + 1) + 1;

    logic                      clk = 1'b0;
    logic                      rst_n = 1'b0;
    logic                      valid_i = 1'b0;
    logic [N-1:0]              word_i = '0;
    logic                      valid_o, sign_o, zero_o, inf_o;
    logic signed [SCALE_W-1:0] scale_o;
    logic [FRAC_W:0]           frac_o;

    int n_checks = 0;
    int n_fail = 0;

    // Expected output state, kept by the bench
    int e_valid = 0, e_sign = 0, e_zero = 1, e_inf = 0, e_scale = 0, e_frac = 0;

    always #4 clk = ~clk;

    posit_word_decoder #(.N(N), .ES(ES)) dut_i (
        .clk_i(clk), .rst_ni(rst_n), .valid_i(valid_i), .word_i(word_i),
        .valid_o(valid_o), .sign_o(sign_o), .zero_o(zero_o), .inf_o(inf_o),
        .scale_o(scale_o), .frac_o(frac_o)
    );

    task automatic check(input string tag, input int act, input int expv);
        n_checks++;
        if (act != expv) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
        end
    endtask

    // Bit-serial decoder of one code
    task automatic ref_decode(input int w, output int s, output int z, output int inf,
                              output int sc, output int fr);
        int mag, lead, m, i, ex, f, reg_v;
        s = (w >> (N - 1)) & 1;
        z = (w == 0) ? 1 : 0;
        inf = (w == (1 << (N - 1))) ? 1 : 0;
        sc = 0;
        fr = 0;
        if (z == 0 && inf == 0) begin
            mag = s ? ((1 << N) - w) : w;
            i = N - 2;
            lead = (mag >> i) & 1;
            m = 0;
            while (i >= 0 && ((mag >> i) & 1) == lead) begin
                m++;
                i--;
            end
            i--;
            reg_v = lead ? (m - 1) : -m;
            ex = 0;
            for (int e = 0; e < ES; e++) begin
                ex = ex * 2 + ((i >= 0) ? ((mag >> i) & 1) : 0);
                i--;
            end
            f = 0;
            for (int j = 0; j < FRAC_W; j++) begin
                f = f * 2 + ((i >= 0) ? ((mag >> i) & 1) : 0);
                i--;
            end
            sc = reg_v * (1 << ES) + ex;
            fr = (1 << FRAC_W) | f;
        end
    endtask

    task automatic compare_all(input string ctx);
        check({"R9 valid_o ", ctx}, int'(valid_o), e_valid);
        check({"R3 sign_o ", ctx}, int'(sign_o), e_sign);
        check({"R1 zero_o ", ctx}, int'(zero_o), e_zero);
        check({"R2 inf_o ", ctx}, int'(inf_o), e_inf);
        check({"R4/R5 scale_o ", ctx}, int'(scale_o), e_scale);
        check({"R8 frac_o ", ctx}, int'(frac_o), e_frac);
    endtask

    task automatic apply(input int w, input bit v, input string ctx);
        @(negedge clk);
        valid_i = v;
        word_i = N'(w);
        @(posedge clk);
        e_valid = v;
        if (v) ref_decode(w, e_sign, e_zero, e_inf, e_scale, e_frac);
        @(negedge clk);
        compare_all(ctx);
    endtask

    initial begin : watchdog
        #(8 * 150000);
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        compare_all("R11 in reset");
        rst_n = 1'b1;
        @(negedge clk);
        compare_all("R11 after reset");

        // Exhaustive sweep, idle cycles between groups (R10 hold, R9 drop)
        for (int w = 0; w < (1 << N); w++) begin
            apply(w, 1'b1, "sweep");
            if ((w % 16) == 15) apply(w ^ 8'h5A, 1'b0, "R10 idle");
        end

        // Directed corner codes, fixed values for N=8, ES=1
        apply(8'h50, 1'b1, "R4");
        check("R4 0x50 scale", int'(scale_o), 1);
        apply(8'h20, 1'b1, "R5");
        check("R5 0x20 scale", int'(scale_o), -2);
        apply(8'h7F, 1'b1, "R6");
        check("R6 0x7F scale", int'(scale_o), 12);
        check("R6 0x7F frac", int'(frac_o), 16);
        apply(8'h01, 1'b1, "R6");
        check("R6 0x01 scale", int'(scale_o), -12);
        apply(8'h7E, 1'b1, "R7");
        check("R7 0x7E scale", int'(scale_o), 10);
        apply(8'h47, 1'b1, "R8");
        check("R8 0x47 frac", int'(frac_o), 23);
        apply(8'hC0, 1'b1, "R3");
        check("R3 0xC0 scale", int'(scale_o), 0);
        check("R3 0xC0 sign", int'(sign_o), 1);
        apply(8'h80, 1'b1, "R2");
        check("R2 0x80 inf", int'(inf_o), 1);
        apply(8'h00, 1'b1, "R1");
        check("R1 0x00 zero", int'(zero_o), 1);
        apply(8'h33, 1'b0, "R10");
        check("R10 held zero", int'(zero_o), 1);

        $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule